// File: doc/BRIEF.md
# Double-Data-Rate Sample Word Serializer

This block models the digital output stage of a data converter. On every rising edge of its sample clock it takes one 12-bit word and, after a fixed latency, sends that word bit by bit on a single serial line. A bit clock goes out with the data, and a frame marker shows where each word starts. The bit clock runs at six times the sample rate. Data changes on both edges of the bit clock, so a whole word leaves in one sample period.

Everything runs from one fast input clock at twelve times the sample rate, which is one fast cycle per serial bit. A phase counter divides that clock down to the sample clock and the bit clock, and both leave the block as outputs. The incoming word is captured into a delay line and loaded into a shifter half a sample period off the capture phase. That gives a latency of six and a half sample periods from the capture edge to the first bit. Words follow one another with no gap. When the valid input is low, an all-zero word takes the slot, so the serial timing never stalls.

Top module: `ddr_word_serializer`

## Requirements
- R1: The sample clock output rises on the fast edge that captures a sample. It is high for 6 fast cycles and low for 6, with a period of 12 fast cycles. It reads 0 during reset.
- R2: The bit clock output toggles on every fast edge, so it runs at six times the sample clock. It is high right after each sample capture edge and reads 0 during reset.
- R3: The input word is captured on the rising sample-clock edge when the valid input is 1. The first such edge is the first fast edge after reset is released.
- R4: Each word leaves least-significant bit first, D0 through D11, with one bit per fast cycle. The serial line therefore changes on both bit-clock edges.
- R5: D0 of a word appears on the fast edge 78 fast cycles after its capture edge, which is 6.5 sample periods.
- R6: D0 of each word follows D11 of the previous word on the very next fast edge, with no idle bit between them.
- R7: The frame output is high while D0 to D5 are on the line and low while D6 to D11 are on the line.
- R8: After reset, the serial line and the frame output stay 0 until D0 of the first captured word appears.
- R9: A sample edge with the valid input at 0 puts an all-zero word in that slot. The frame output keeps its usual pattern for that slot.
- R10: An asynchronous active-low reset forces the serial line, frame, sample clock and bit clock outputs to 0 at once, and the capture sequence restarts when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock at twelve times the sample rate, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_word | input | 12 | Sample word to capture |
| smp_valid | input | 1 | Sample word is valid; 0 inserts an all-zero word |
| smp_clk_o | output | 1 | Derived sample clock; its rising edge is the capture edge |
| bit_clk_o | output | 1 | Bit clock at six times the sample clock |
| frame_o | output | 1 | Word marker, high for the first half of each word |
| sdata_o | output | 1 | Serial data, least-significant bit first |

## Verification
Every result is tied to the count k of fast edges since reset was released, where edge 0 captures sample 0. After edge k the sample clock is due as k mod 12 < 6 and the bit clock as k even. From edge 78 onward, bit (k-78) mod 12 of sample (k-78)/12 is due on the serial line, and frame is due as that bit index < 6. The bench drives each new word on the falling edge before the capture edge. It advances k on every rising edge and compares all four outputs on the next falling edge against a word list it keeps itself. A reset asserted mid-stream is checked asynchronously, one time unit after it falls.

// File: rtl/ddr_ser_pkg.sv
package ddr_ser_pkg;

  // Delay-line stage read by the shifter load. Stage 0 is the capture register.
  function automatic int read_stage(input int lat_halves);
    return (lat_halves % 2 == 1) ? lat_halves / 2 : lat_halves / 2 - 1;
  endfunction

  // Phase value seen just before the edge that loads the shifter.
  function automatic int load_phase(input int word_w, input int lat_halves);
    return (lat_halves % 2 == 1) ? word_w / 2 - 1 : word_w - 1;
  endfunction

  // Frame level for the bit with index idx inside a word.
  function automatic logic frame_level(input int idx, input int word_w);
    return (idx < word_w / 2);
  endfunction

endpackage

// File: rtl/ser_phase_gen.sv
module ser_phase_gen
  import ddr_ser_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int LAT_HALVES = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o,
  output logic load_o,
  output logic smp_clk_o,
  output logic bit_clk_o
);
  localparam int PW = $clog2(WORD_W);
  localparam logic [PW-1:0] PH_LAST = PW'(WORD_W - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(WORD_W / 2);
  localparam logic [PW-1:0] PH_LOAD = PW'(load_phase(WORD_W, LAT_HALVES));

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= PH_LAST;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  assign tick_o    = (phase_q == PH_LAST);
  assign load_o    = (phase_q == PH_LOAD);
  assign smp_clk_o = (phase_q < PH_HALF);
  assign bit_clk_o = ~phase_q[0];

  // R1
  smp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> $rose(smp_clk_o));

  // R2
  bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk_o |=> !bit_clk_o);

  // R2
  bclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_clk_o |=> bit_clk_o);

endmodule

// File: rtl/ser_latency_line.sv
module ser_latency_line
  import ddr_ser_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int LAT_HALVES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic [WORD_W-1:0] word_o,
  output logic              live_o
);
  localparam int RD = read_stage(LAT_HALVES);

  logic [WORD_W-1:0] stg_q  [0:RD];
  logic              live_q [0:RD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q[0]  <= '0;
      live_q[0] <= 1'b0;
    end else if (tick_i) begin
      stg_q[0]  <= valid_i ? word_i : '0;
      live_q[0] <= 1'b1;
    end
  end

  for (genvar i = 1; i <= RD; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[i]  <= '0;
        live_q[i] <= 1'b0;
      end else if (tick_i) begin
        stg_q[i]  <= stg_q[i-1];
        live_q[i] <= live_q[i-1];
      end
    end
  end

  assign word_o = stg_q[RD];
  assign live_o = live_q[RD];

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && valid_i |=> stg_q[0] == $past(word_i));

  // R9
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !valid_i |=> stg_q[0] == '0);

endmodule

// File: rtl/ser_word_shifter.sv
module ser_word_shifter
  import ddr_ser_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              live_i,
  output logic              sdata_o,
  output logic              frame_o,
  output logic              primed_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] CNT_LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nx;
  logic              frame_q;
  logic              primed_q;

  assign cnt_nx = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      frame_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (load_i) begin
      sh_q     <= live_i ? word_i : '0;
      cnt_q    <= '0;
      frame_q  <= live_i && frame_level(0, WORD_W);
      primed_q <= primed_q | live_i;
    end else begin
      sh_q     <= sh_q >> 1;
      cnt_q    <= cnt_nx;
      frame_q  <= primed_q && frame_level(int'(cnt_nx), WORD_W);
    end
  end

  assign sdata_o  = sh_q[0];
  assign frame_o  = frame_q;
  assign primed_o = primed_q;

  // R6
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && primed_q |-> cnt_q == CNT_LAST);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> !sdata_o && !frame_o);

endmodule

// File: rtl/ddr_word_serializer.sv
module ddr_word_serializer #(
  parameter int WORD_W     = 12,
  parameter int LAT_HALVES = 13
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              smp_valid,
  output logic              smp_clk_o,
  output logic              bit_clk_o,
  output logic              frame_o,
  output logic              sdata_o
);
  logic              tick_w;
  logic              load_w;
  logic [WORD_W-1:0] dly_word_w;
  logic              dly_live_w;
  logic              primed_w;

  ser_phase_gen #(.WORD_W(WORD_W), .LAT_HALVES(LAT_HALVES)) u_phase (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .tick_o   (tick_w),
    .load_o   (load_w),
    .smp_clk_o(smp_clk_o),
    .bit_clk_o(bit_clk_o)
  );

  ser_latency_line #(.WORD_W(WORD_W), .LAT_HALVES(LAT_HALVES)) u_line (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .tick_i (tick_w),
    .word_i (smp_word),
    .valid_i(smp_valid),
    .word_o (dly_word_w),
    .live_o (dly_live_w)
  );

  ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .word_i  (dly_word_w),
    .live_i  (dly_live_w),
    .sdata_o (sdata_o),
    .frame_o (frame_o),
    .primed_o(primed_w)
  );

  // R7
  frame_start_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load_w && dly_live_w |=> frame_o);

endmodule

// File: tb/ddr_word_serializer_bench.sv
module ddr_word_serializer_bench;
  localparam int W      = 12;
  localparam int LAT_FC = (13 * W) / 2;  // 6.5 sample periods in fast cycles

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] smp_word = '0;
  logic         smp_valid = 1'b0;
  logic         smp_clk_o, bit_clk_o, frame_o, sdata_o;

  int n_chk = 0;
  int n_fail = 0;
  int k = -1;
  logic [W-1:0] exp_w [0:511];
  logic         exp_v [0:511];

  always #5 clk = ~clk;

  ddr_word_serializer u_ddr_word_serializer (
    .clk_fast (clk),
    .rst_n    (rst_n),
    .smp_word (smp_word),
    .smp_valid(smp_valid),
    .smp_clk_o(smp_clk_o),
    .bit_clk_o(bit_clk_o),
    .frame_o  (frame_o),
    .sdata_o  (sdata_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at edge %0d", tag, what, act, exp, k);
    end
  endtask

  task automatic check_outputs();
    int b = k - LAT_FC;
    logic e_sd = 1'b0;
    logic e_fr = 1'b0;
    string t_sd = "R8";
    string t_fr = "R8";
    if (b >= 0) begin
      e_sd = exp_w[(b / W) & 511][b % W];
      e_fr = (b % W) < (W / 2);
      t_fr = "R7";
      t_sd = exp_v[(b / W) & 511] ? "R3 R4 R5 R6" : "R9";
    end
    chk(sdata_o, e_sd, t_sd, "sdata");
    chk(frame_o, e_fr, t_fr, "frame");
    chk(smp_clk_o, (k % W) < (W / 2), "R1", "sample clock");
    chk(bit_clk_o, (k % 2) == 0, "R2", "bit clock");
  endtask

  function automatic logic [W-1:0] gen_word(input int mode, input int n);
    case (mode)
      0:       return W'(12'h013 + n * 37);
      1:       return W'(1) << (n % W);
      2:       return (n % 2 == 1) ? 12'hAAA : 12'h555;
      default: return 12'hF0F ^ W'(n);
    endcase
  endfunction

  task automatic run(input int nsamp, input int mode);
    for (int c = 0; c < nsamp * W; c++) begin
      if ((k + 1) % W == 0) begin
        int n = (k + 1) / W;
        smp_word  = gen_word(mode, n);
        smp_valid = (mode == 3) ? (n % 2 == 0) : 1'b1;
        exp_v[n & 511] = smp_valid;
        exp_w[n & 511] = smp_valid ? smp_word : '0;
      end
      @(posedge clk);
      k++;
      @(negedge clk);
      check_outputs();
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdata_o, 1'b0, "R8", "sdata in reset");
    chk(frame_o, 1'b0, "R8", "frame in reset");
    chk(smp_clk_o, 1'b0, "R1", "sample clock in reset");
    chk(bit_clk_o, 1'b0, "R2", "bit clock in reset");
    rst_n = 1'b1;
    k = -1;
  endtask

  task automatic t_ramp();    run(10, 0); endtask  // R4 R5 R8 fill then ramp
  task automatic t_walk();    run(14, 1); endtask  // R4 walking one
  task automatic t_alt();     run(8, 2);  endtask  // R6 back-to-back toggling words
  task automatic t_gaps();    run(12, 3); endtask  // R9 every other slot invalid

  task automatic t_restart();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(sdata_o, 1'b0, "R10", "sdata on async reset");
    chk(frame_o, 1'b0, "R10", "frame on async reset");
    chk(smp_clk_o, 1'b0, "R10", "sample clock on async reset");
    chk(bit_clk_o, 1'b0, "R10", "bit clock on async reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = -1;
    run(10, 0);  // R10 restart sequence matches a fresh start
  endtask

  initial begin
    t_reset_state();
    t_ramp();
    t_walk();
    t_alt();
    t_gaps();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule